// File: doc/BRIEF.md
# Processor Fault Escalation Controller

This block sits beside a processor core and turns raw fault-event pulses into a single exception request per cycle. Three configurable fault classes arrive from the core: memory-protection faults, bus faults and usage faults. Three other sources always end in the catch-all HardFault: a bus error taken while fetching a vector, a breakpoint that no debug agent will service, and a supervisor call issued from inside the supervisor-call handler. A divide by zero only counts as a usage fault when the trap for it is armed.

Software sets per-class enable bits and priority fields over a simple word-addressed register port. A configurable fault is routed to its own exception only when it is enabled and the core is not already running a handler of equal or more urgent priority. Otherwise the fault is escalated to HardFault. A sticky status word records why a HardFault was raised, and software clears it by writing ones. The chosen exception number and its priority are presented, one cycle after the event, to a downstream arbiter.

Top module: `fault_route_ctrl`

## Requirements
- R1: After reset, `exc_valid` is 0 and words 0, 1 and 2 of the register port all read 0.
- R2: An enabled, unblocked configurable fault makes `exc_valid` go high on the next clock edge for one cycle. `exc_num` is then 4 for memory, 5 for bus and 6 for usage, and `exc_prio` is the zero-extended priority field of that fault.
- R3: Whenever `exc_num` is 3 (HardFault), `exc_prio` is all ones, which is -1 in two's complement.
- R4: Word 0 is the control register. Bit 16 enables memory faults, bit 17 enables bus faults and bit 18 enables usage faults. These bits read back as written, and all other bits read 0.
- R5: A configurable fault whose enable bit is 0 raises exception 3 and sets status bit 30.
- R6: A vector-fetch bus error always raises exception 3 and sets status bit 1, whatever the bus-fault enable is.
- R7: A breakpoint with both `halt_en` and `mon_en` low raises exception 3 and sets status bit 31. With either input high, the breakpoint raises nothing and leaves status unchanged.
- R8: A supervisor call while `svc_active` is high raises exception 3 and sets status bit 30. Without `svc_active`, it raises nothing.
- R9: With `dz_trap_en` high, a divide by zero is handled as a usage fault. With `dz_trap_en` low, it raises nothing, and `zap_quotient` is high in the same cycle as the event.
- R10: A configurable fault that arrives while `ctx_active` is high and the signed `ctx_prio` is less than or equal to that fault's priority escalates to exception 3 and sets status bit 30.
- R11: Word 2 is the status register, with bits 31, 30 and 1 in use. Each bit stays set until a write to word 2 has a 1 in that position. If a set and a clear of the same bit fall in one cycle, the set wins.
- R12: When several faults resolve in the same cycle, `exc_num` is the lowest exception number among them. Every status bit that any of them causes is still set.
- R13: Word 1 holds the priority fields, each PRIO_W bits wide: memory at bit 0, bus at bit 8 and usage at bit 16. All three reset to 0, and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| ev_mem | input | 1 | Memory-protection fault event |
| ev_bus | input | 1 | Bus fault event |
| ev_usage | input | 1 | Usage fault event |
| ev_vecbus | input | 1 | Bus error during vector fetch |
| ev_bkpt | input | 1 | Breakpoint event |
| ev_svc | input | 1 | Supervisor call event |
| ev_divzero | input | 1 | Divide by zero event |
| halt_en | input | 1 | Halting debug enabled |
| mon_en | input | 1 | Debug monitor enabled |
| svc_active | input | 1 | Supervisor-call handler is active |
| dz_trap_en | input | 1 | Divide-by-zero trap armed |
| ctx_active | input | 1 | Core is running a handler |
| ctx_prio | input | PRIO_W+1 | Signed priority of the running handler |
| exc_valid | output | 1 | Exception request pulse |
| exc_num | output | 4 | Requested exception number |
| exc_prio | output | PRIO_W+1 | Signed priority of the request |
| zap_quotient | output | 1 | Force divide result to zero |

## Verification
The hardest cases to reach are the interactions: a fault that is enabled but still escalates because of the running context, and several sources landing in the same cycle under different debug and trap settings. The stimulus sweeps every enable mask against each configurable source and nine context priorities that straddle each configured field. It then drives all 128 event combinations under all 16 settings of the four qualifying inputs. A separate step makes a status set and its write-one clear coincide.

// File: rtl/fault_route_pkg.sv
package fault_route_pkg;
  localparam int unsigned NUM_CFG  = 3;   // memory, bus, usage
  localparam int unsigned EN_LSB   = 16;  // first enable bit in control word
  localparam int unsigned LANE_W   = 8;   // priority field lane spacing
  localparam int unsigned ST_VECT  = 1;
  localparam int unsigned ST_FORCE = 30;
  localparam int unsigned ST_DEBUG = 31;

  localparam logic [3:0] EXC_NONE  = 4'd0;
  localparam logic [3:0] EXC_HARD  = 4'd3;
  localparam logic [3:0] EXC_FIRST = 4'd4;  // number of configurable fault 0

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_PRIO = 2'd1;
  localparam logic [1:0] RA_STAT = 2'd2;

  typedef struct packed {
    logic debug;
    logic forced;
    logic vect;
  } hf_cause_t;
endpackage

// File: rtl/fault_cfg_regs.sv
module fault_cfg_regs
  import fault_route_pkg::*;
#(
  parameter int unsigned PRIO_W = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  logic [1:0]                       addr,
  input  logic [31:0]                      wdata,
  output logic [NUM_CFG-1:0]               en_o,
  output logic [NUM_CFG-1:0][PRIO_W-1:0]   prio_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_o <= '0;
    else if (we && addr == RA_CTRL) en_o <= wdata[EN_LSB +: NUM_CFG];
  end

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_prio
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prio_o[i] <= '0;
      else if (we && addr == RA_PRIO) prio_o[i] <= wdata[LANE_W*i +: PRIO_W];
    end
  end
endmodule

// File: rtl/fault_router.sv
module fault_router
  import fault_route_pkg::*;
#(
  parameter int unsigned PRIO_W = 3
) (
  input  logic [NUM_CFG-1:0]             cfg_ev,
  input  logic [NUM_CFG-1:0]             en,
  input  logic [NUM_CFG-1:0][PRIO_W-1:0] prio_f,
  input  logic                           ctx_active,
  input  logic signed [PRIO_W:0]         ctx_prio,
  input  logic                           ev_vecbus,
  input  logic                           ev_bkpt,
  input  logic                           ev_svc,
  input  logic                           halt_en,
  input  logic                           mon_en,
  input  logic                           svc_active,
  output logic [NUM_CFG-1:0]             own_raise,
  output hf_cause_t                      cause,
  output logic                           nxt_valid,
  output logic [3:0]                     nxt_num,
  output logic [PRIO_W:0]                nxt_prio
);
  // A handler of equal or more urgent priority is running
  function automatic logic ctx_blocks(input logic act,
                                      input logic signed [PRIO_W:0] cp,
                                      input logic [PRIO_W-1:0] fp);
    return act && (cp <= $signed({1'b0, fp}));
  endfunction

  logic [NUM_CFG-1:0] esc;

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_route
    assign own_raise[i] = cfg_ev[i] &&  en[i] && !ctx_blocks(ctx_active, ctx_prio, prio_f[i]);
    assign esc[i]       = cfg_ev[i] && !own_raise[i];
  end

  assign cause.vect   = ev_vecbus;
  assign cause.debug  = ev_bkpt && !halt_en && !mon_en;
  assign cause.forced = (|esc) || (ev_svc && svc_active);

  always_comb begin
    nxt_valid = 1'b0;
    nxt_num   = EXC_NONE;
    nxt_prio  = '0;
    // highest index first so the lowest number is left standing
    for (int i = NUM_CFG - 1; i >= 0; i--) begin
      if (own_raise[i]) begin
        nxt_valid = 1'b1;
        nxt_num   = EXC_FIRST + 4'(i);
        nxt_prio  = {1'b0, prio_f[i]};
      end
    end
    if (|cause) begin
      nxt_valid = 1'b1;
      nxt_num   = EXC_HARD;
      nxt_prio  = '1;
    end
  end
endmodule

// File: rtl/fault_status.sv
module fault_status
  import fault_route_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr_we,
  input  logic [31:0] wdata,
  input  hf_cause_t   set_i,
  output hf_cause_t   stat_o
);
  hf_cause_t clr_mask;
  assign clr_mask.debug  = clr_we && wdata[ST_DEBUG];
  assign clr_mask.forced = clr_we && wdata[ST_FORCE];
  assign clr_mask.vect   = clr_we && wdata[ST_VECT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_o <= '0;
    else        stat_o <= set_i | (stat_o & ~clr_mask);
  end
endmodule

// File: rtl/fault_route_ctrl.sv
module fault_route_ctrl
  import fault_route_pkg::*;
#(
  parameter int unsigned PRIO_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_we,
  input  logic [1:0]             reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  input  logic                   ev_mem,
  input  logic                   ev_bus,
  input  logic                   ev_usage,
  input  logic                   ev_vecbus,
  input  logic                   ev_bkpt,
  input  logic                   ev_svc,
  input  logic                   ev_divzero,
  input  logic                   halt_en,
  input  logic                   mon_en,
  input  logic                   svc_active,
  input  logic                   dz_trap_en,
  input  logic                   ctx_active,
  input  logic signed [PRIO_W:0] ctx_prio,
  output logic                   exc_valid,
  output logic [3:0]             exc_num,
  output logic [PRIO_W:0]        exc_prio,
  output logic                   zap_quotient
);
  localparam int unsigned OUT_W = PRIO_W + 1;

  logic [NUM_CFG-1:0]             en_bits;
  logic [NUM_CFG-1:0][PRIO_W-1:0] prio_f;
  logic [NUM_CFG-1:0]             cfg_ev;
  logic [NUM_CFG-1:0]             own_raise;
  hf_cause_t                      cause;
  hf_cause_t                      stat;
  logic                           nxt_valid;
  logic [3:0]                     nxt_num;
  logic [OUT_W-1:0]               nxt_prio;
  logic                           dz_trap;

  assign dz_trap      = ev_divzero && dz_trap_en;
  assign zap_quotient = ev_divzero && !dz_trap_en;
  assign cfg_ev       = {ev_usage || dz_trap, ev_bus, ev_mem};

  fault_cfg_regs #(.PRIO_W(PRIO_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .en_o(en_bits), .prio_o(prio_f)
  );

  fault_router #(.PRIO_W(PRIO_W)) u_route (
    .cfg_ev(cfg_ev), .en(en_bits), .prio_f(prio_f),
    .ctx_active(ctx_active), .ctx_prio(ctx_prio),
    .ev_vecbus(ev_vecbus), .ev_bkpt(ev_bkpt), .ev_svc(ev_svc),
    .halt_en(halt_en), .mon_en(mon_en), .svc_active(svc_active),
    .own_raise(own_raise), .cause(cause),
    .nxt_valid(nxt_valid), .nxt_num(nxt_num), .nxt_prio(nxt_prio)
  );

  fault_status u_stat (
    .clk(clk), .rst_n(rst_n),
    .clr_we(reg_we && reg_addr == RA_STAT),
    .wdata(reg_wdata), .set_i(cause), .stat_o(stat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_valid <= 1'b0;
      exc_num   <= EXC_NONE;
      exc_prio  <= '0;
    end else begin
      exc_valid <= nxt_valid;
      exc_num   <= nxt_num;
      exc_prio  <= nxt_prio;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL: reg_rdata[EN_LSB +: NUM_CFG] = en_bits;
      RA_PRIO: for (int i = 0; i < NUM_CFG; i++) reg_rdata[LANE_W*i +: PRIO_W] = prio_f[i];
      RA_STAT: begin
        reg_rdata[ST_DEBUG] = stat.debug;
        reg_rdata[ST_FORCE] = stat.forced;
        reg_rdata[ST_VECT]  = stat.vect;
      end
      default: reg_rdata = '0;
    endcase
  end

  logic unused_own;
  assign unused_own = ^own_raise;
endmodule

// File: rtl/fault_route_chk.sv
module fault_route_chk
  import fault_route_pkg::*;
#(
  parameter int unsigned PRIO_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [1:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              ev_mem,
  input logic              ev_bus,
  input logic              ev_usage,
  input logic              ev_vecbus,
  input logic              ev_bkpt,
  input logic              ev_svc,
  input logic              ev_divzero,
  input logic              halt_en,
  input logic              mon_en,
  input logic              dz_trap_en,
  input logic [NUM_CFG-1:0] en_bits,
  input hf_cause_t         stat,
  input logic              exc_valid,
  input logic [3:0]        exc_num,
  input logic [PRIO_W:0]   exc_prio
);
  assert_hard_prio_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_num == EXC_HARD) |-> (exc_prio == '1));

  assert_num_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (exc_num >= 4'd3 && exc_num <= 4'd6));

  assert_vect_hard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vecbus |=> (exc_valid && exc_num == EXC_HARD && stat.vect));

  assert_forced_mem_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_mem && !en_bits[0]) |=> (exc_valid && exc_num == EXC_HARD && stat.forced));

  assert_bkpt_debug_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bkpt && !halt_en && !mon_en) |=> stat.debug);

  assert_forced_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (stat.forced && !(reg_we && reg_addr == RA_STAT && reg_wdata[ST_FORCE])) |=> stat.forced);

  assert_dz_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_divzero && !dz_trap_en && !ev_mem && !ev_bus && !ev_usage &&
     !ev_vecbus && !ev_bkpt && !ev_svc) |=> !exc_valid);
endmodule

bind fault_route_ctrl fault_route_chk #(.PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .ev_mem(ev_mem), .ev_bus(ev_bus),
  .ev_usage(ev_usage), .ev_vecbus(ev_vecbus), .ev_bkpt(ev_bkpt),
  .ev_svc(ev_svc), .ev_divzero(ev_divzero), .halt_en(halt_en),
  .mon_en(mon_en), .dz_trap_en(dz_trap_en), .en_bits(en_bits),
  .stat(stat), .exc_valid(exc_valid), .exc_num(exc_num),
  .exc_prio(exc_prio)
);

// File: tb/fault_route_ctrl_bench.sv
module fault_route_ctrl_bench;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic ev_mem = 0, ev_bus = 0, ev_usage = 0, ev_vecbus = 0, ev_bkpt = 0, ev_svc = 0, ev_divzero = 0;
  logic halt_en = 0, mon_en = 0, svc_active = 0, dz_trap_en = 0, ctx_active = 0;
  logic signed [PW:0] ctx_prio = '0;
  logic exc_valid;
  logic [3:0] exc_num;
  logic [PW:0] exc_prio;
  logic zap_quotient;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] exp_stat = '0;
  int pr [3];
  logic [2:0] cur_en;

  always #2 clk = ~clk;  // 250 MHz

  fault_route_ctrl #(.PRIO_W(PW)) u_fault_route_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_mem(ev_mem), .ev_bus(ev_bus), .ev_usage(ev_usage),
    .ev_vecbus(ev_vecbus), .ev_bkpt(ev_bkpt), .ev_svc(ev_svc),
    .ev_divzero(ev_divzero), .halt_en(halt_en), .mon_en(mon_en),
    .svc_active(svc_active), .dz_trap_en(dz_trap_en),
    .ctx_active(ctx_active), .ctx_prio(ctx_prio),
    .exc_valid(exc_valid), .exc_num(exc_num), .exc_prio(exc_prio),
    .zap_quotient(zap_quotient)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input string req, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 chk(req, reg_rdata, exp);
  endtask

  // Drive one cycle of events, check the response, then check and clear status.
  task automatic fire(input logic [6:0] ev, input string req);
    logic [2:0] cfg;
    logic [2:0] own;
    logic forced, vect, dbg;
    logic [3:0] e_num;
    logic [PW:0] e_prio;
    logic [31:0] setw;
    cfg = {ev[2] | (ev[6] & dz_trap_en), ev[1], ev[0]};
    own = '0; forced = 0;
    for (int i = 0; i < 3; i++) begin
      if (cfg[i]) begin
        if (cur_en[i] && !(ctx_active && int'(ctx_prio) <= pr[i])) own[i] = 1;
        else forced = 1;
      end
    end
    if (ev[5] && svc_active) forced = 1;
    vect = ev[3];
    dbg  = ev[4] && !halt_en && !mon_en;
    e_num = 4'd0; e_prio = '0;
    if (forced || vect || dbg) begin e_num = 4'd3; e_prio = '1; end
    else begin
      for (int i = 2; i >= 0; i--)
        if (own[i]) begin e_num = 4'(4 + i); e_prio = PW'(pr[i]) & {1'b0, {PW{1'b1}}}; end
    end
    setw = (32'(dbg) << 31) | (32'(forced) << 30) | (32'(vect) << 1);
    @(negedge clk);
    {ev_divzero, ev_svc, ev_bkpt, ev_vecbus, ev_usage, ev_bus, ev_mem} = ev;
    #1 chk({req, " R9 zap"}, 32'(zap_quotient), 32'(ev[6] & !dz_trap_en));
    @(posedge clk);
    #1;
    chk({req, " valid"}, 32'(exc_valid), 32'(e_num != 0));
    chk({req, " num R12"}, 32'(exc_num), 32'(e_num));
    if (e_num != 0) chk({req, " prio R3"}, 32'(exc_prio), 32'(e_prio));
    @(negedge clk);
    {ev_divzero, ev_svc, ev_bkpt, ev_vecbus, ev_usage, ev_bus, ev_mem} = '0;
    reg_addr = 2'd2;
    exp_stat = exp_stat | setw;
    #1 chk({req, " status R11"}, reg_rdata, exp_stat);
    if (exp_stat != 0) begin
      wr(2'd2, 32'hFFFF_FFFF);
      exp_stat = '0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 exc_valid", 32'(exc_valid), 32'd0);
    rd(2'd0, "R1 ctrl", 32'd0);
    rd(2'd1, "R1 prio", 32'd0);
    rd(2'd2, "R1 stat", 32'd0);
    rst_n = 1'b1;

    // R4 / R13 register read-back
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, "R4 ctrl all ones", 32'h0007_0000);
    wr(2'd0, 32'h0002_0000);
    rd(2'd0, "R4 ctrl bus only", 32'h0002_0000);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, "R13 prio all ones", 32'h0007_0707);
    pr[0] = 2; pr[1] = 5; pr[2] = 0;
    wr(2'd1, 32'(pr[0]) | (32'(pr[1]) << 8) | (32'(pr[2]) << 16));
    rd(2'd1, "R13 prio fields", 32'h0000_0502);
    rd(2'd3, "R4 unused word", 32'd0);

    // Default enables: everything escalates (R5)
    wr(2'd0, 32'd0); cur_en = 3'b000;
    fire(7'b0000001, "R5 mem disabled");
    fire(7'b0000100, "R5 usage disabled");

    // Sweep enables x source x context (R2 R5 R10)
    for (int en = 0; en < 8; en++) begin
      cur_en = 3'(en);
      wr(2'd0, 32'(en) << 16);
      for (int s = 0; s < 3; s++) begin
        for (int a = 0; a < 2; a++) begin
          for (int c = -1; c < 8; c++) begin
            ctx_active = a[0];
            ctx_prio = 4'(c);
            fire(7'(1 << s), "R2 R10 sweep");
          end
        end
      end
    end
    ctx_active = 0; ctx_prio = '0;

    // All event combinations under all qualifiers (R6 R7 R8 R9 R12)
    cur_en = 3'b101;
    wr(2'd0, 32'h0005_0000);
    for (int q = 0; q < 16; q++) begin
      {halt_en, mon_en, svc_active, dz_trap_en} = 4'(q);
      for (int ev = 0; ev < 128; ev++) fire(7'(ev), "R6 R7 R8 R9 combo");
    end
    {halt_en, mon_en, svc_active, dz_trap_en} = '0;

    // R6 with bus fault enabled: still HardFault
    cur_en = 3'b111;
    wr(2'd0, 32'h0007_0000);
    fire(7'b0001000, "R6 vecbus with bus enabled");

    // R11: set wins over simultaneous clear, partial clear keeps others
    @(negedge clk);
    ev_vecbus = 1; ev_bkpt = 1;
    reg_we = 1; reg_addr = 2'd2; reg_wdata = 32'h0000_0002;
    @(negedge clk);
    ev_vecbus = 0; ev_bkpt = 0; reg_we = 0;
    #1 chk("R11 set beats clear", reg_rdata, 32'h8000_0002);
    wr(2'd2, 32'h8000_0000);
    rd(2'd2, "R11 partial clear", 32'h0000_0002);
    wr(2'd2, 32'h4000_0000);
    rd(2'd2, "R11 clear of unset bit", 32'h0000_0002);
    wr(2'd2, 32'h0000_0002);
    rd(2'd2, "R11 cleared", 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule